// File: doc/BRIEF.md
# PC Card Byte-Lane Steering

This block sits between the 16-bit data connector of a PC Card and two byte-wide memory halves, one holding even byte addresses and one holding odd byte addresses. From the two active-low card enables, the low address bit, the output and write enables and the attribute-space select, it decides which half is read or written. It also decides which connector lane carries which byte and which lane the pad ring may drive. Both 8-bit and 16-bit hosts can therefore reach every byte. An 8-bit host reaches odd bytes on the low lane by setting the low address bit. A 16-bit host gets whole words, or odd bytes alone on the high lane.

The connector pins are sampled on each rising clock edge. The whole decoded set of strobes is registered, so every control output and the write data appear exactly one cycle after the pins that caused them. Read data from the memory halves passes combinationally onto the connector data output, gated by the registered lane enables.

Attribute space (select low) holds only even bytes. In that space, odd-byte reads give a constant fill pattern and odd-byte writes never reach a memory half.

Top module: `pccard_lane_steer`

## Requirements
- R1: While reset is asserted and in the cycle after it, all lane drive enables, read enables, write strobes, the odd-to-low select, the attribute flag and the data output are 0.
- R2: With both card enables high (standby), one cycle later no lane is driven, no read enable or write strobe is set, and the data output is 0.
- R3: A read needs output enable low with write enable high; a write needs write enable low with output enable high. With both low or both high, nothing is driven, read or written.
- R4: Card enable 1 low, card enable 2 high, address bit 0 = 0: a read drives only the low lane (laneOe = 2'b01) with the even byte; a write strobes only the even half with data from bits 7:0.
- R5: Card enable 1 low, card enable 2 high, address bit 0 = 1: a read drives only the low lane with the odd byte and sets lowLaneFromOdd; a write strobes only the odd half with data from bits 7:0.
- R6: Both card enables low (word): address bit 0 is ignored. A read drives both lanes (laneOe = 2'b11), with the odd byte on bits 15:8 and the even byte on bits 7:0. A write strobes both halves, the odd half taking bits 15:8.
- R7: Card enable 1 high, card enable 2 low (odd only): a read drives only the high lane (laneOe = 2'b10) with the odd byte; a write strobes only the odd half with data from bits 15:8.
- R8: With the attribute select low, the odd read enable and odd write strobe stay 0. A lane that would carry an odd byte is driven with all ones (8'hFF). attrSpace is 1 whenever a card enable is low.
- R9: Lanes are driven only during reads, so a lane enable and a write strobe are never set in the same cycle.
- R10: Every output changes one clock after the pins are sampled, and the write data matches the connector data of that same sampled cycle.
- R11: A lane whose drive enable is 0 shows 0 on its data output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ce1N | input | 1 | Card enable for the even/low lane, active low |
| ce2N | input | 1 | Card enable for the odd/high lane, active low |
| addr0 | input | 1 | Byte address bit 0 |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| regN | input | 1 | Attribute-space select, active low |
| hostDataIn | input | 16 | Data from the connector (write data) |
| hostDataOut | output | 16 | Data to the connector (read data) |
| hostLaneOe | output | 2 | Drive enable per lane: [0] bits 7:0, [1] bits 15:8 |
| lowLaneFromOdd | output | 1 | Low lane carries the odd half |
| evenRdData | input | 8 | Read data from the even half |
| oddRdData | input | 8 | Read data from the odd half |
| evenRdEn | output | 1 | Read enable to the even half |
| oddRdEn | output | 1 | Read enable to the odd half |
| evenWrStb | output | 1 | Write strobe to the even half |
| oddWrStb | output | 1 | Write strobe to the odd half |
| evenWrData | output | 8 | Write data to the even half |
| oddWrData | output | 8 | Write data to the odd half |
| attrSpace | output | 1 | Access targets attribute space |

## Verification
Two functions can meet in one cycle. The first is steering an odd byte onto a lane. The second is the attribute-space rule that suppresses odd bytes. They meet in a word or odd-only read with the attribute select low: the high lane must still be driven, but with the fill pattern, and the odd read enable must stay off. The bench sweeps all 64 combinations of the six control pins several times, with changing data. The attribute and address cases therefore fall in every steering mode, and a reference model checks all outputs on every clock.

// File: rtl/pccard_lane_pkg.sv
package pccard_lane_pkg;
  typedef struct packed {
    logic [1:0] laneOe;
    logic       lowFromOdd;
    logic       lowFill;
    logic       highFill;
    logic       evenRd;
    logic       oddRd;
    logic       evenWr;
    logic       oddWr;
    logic       oddFromHigh;
    logic       attr;
  } laneStrobes_t;
endpackage

// File: rtl/pccard_lane_ctrl.sv
module pccard_lane_ctrl
  import pccard_lane_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ce1N,
  input  logic         ce2N,
  input  logic         addr0,
  input  logic         oeN,
  input  logic         weN,
  input  logic         regN,
  output laneStrobes_t stb
);
  logic isRead, isWrite, enEven, enOdd;
  logic wordAcc, byteLow, evenSel, oddSel, attrSp;
  laneStrobes_t nxt;

  always_comb begin
    isRead  = !oeN && weN;
    isWrite = !weN && oeN;
    enEven  = !ce1N;
    enOdd   = !ce2N;
    wordAcc = enEven && enOdd;
    byteLow = enEven && !enOdd;
    evenSel = wordAcc || (byteLow && !addr0);
    oddSel  = enOdd || (byteLow && addr0);
    attrSp  = !regN;

    nxt             = '0;
    nxt.laneOe[0]   = isRead && enEven;
    nxt.laneOe[1]   = isRead && enOdd;
    nxt.lowFromOdd  = isRead && byteLow && addr0;
    nxt.lowFill     = isRead && attrSp && byteLow && addr0;
    nxt.highFill    = isRead && attrSp && enOdd;
    nxt.evenRd      = isRead && evenSel;
    nxt.oddRd       = isRead && oddSel && !attrSp;
    nxt.evenWr      = isWrite && evenSel;
    nxt.oddWr       = isWrite && oddSel && !attrSp;
    nxt.oddFromHigh = enOdd;
    nxt.attr        = attrSp && (enEven || enOdd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stb <= '0;
    else       stb <= nxt;
  end

  AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (ce1N && ce2N) |=> (stb == '0)); // R2
  AST_RW_QUALIFY: assert property (@(posedge clk) disable iff (!rstN)
    (oeN == weN) |=> (stb.laneOe == 2'b00 && !stb.evenWr && !stb.oddWr && !stb.evenRd && !stb.oddRd)); // R3
  AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (!ce1N && !ce2N && !oeN && weN) |=> (stb.laneOe == 2'b11)); // R6
  AST_ODD_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (ce1N && !ce2N) |=> (!stb.laneOe[0] && !stb.evenWr && !stb.evenRd)); // R7
  AST_ATTR_NO_ODD: assert property (@(posedge clk) disable iff (!rstN)
    (!regN) |=> (!stb.oddWr && !stb.oddRd)); // R8
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    (stb.laneOe != 2'b00) |-> !(stb.evenWr || stb.oddWr)); // R9
endmodule

// File: rtl/pccard_lane_dp.sv
module pccard_lane_dp
  import pccard_lane_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter logic [LANE_W-1:0] FILL = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneStrobes_t        stb,
  input  logic [2*LANE_W-1:0] hostDataIn,
  input  logic [LANE_W-1:0]   evenRdData,
  input  logic [LANE_W-1:0]   oddRdData,
  output logic [2*LANE_W-1:0] hostDataOut,
  output logic [LANE_W-1:0]   evenWrData,
  output logic [LANE_W-1:0]   oddWrData
);
  localparam int BUS_W = 2 * LANE_W;
  localparam int NUM_LANES = BUS_W / LANE_W;

  logic [BUS_W-1:0] hostInQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostInQ <= '0;
    else       hostInQ <= hostDataIn;
  end

  assign evenWrData = hostInQ[LANE_W-1:0];
  assign oddWrData  = stb.oddFromHigh ? hostInQ[BUS_W-1:LANE_W] : hostInQ[LANE_W-1:0];

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : gLane
    logic [LANE_W-1:0] src;
    logic              fill;
    if (gi == 0) begin : gLow
      assign src  = stb.lowFromOdd ? oddRdData : evenRdData;
      assign fill = stb.lowFill;
    end else begin : gHigh
      assign src  = oddRdData;
      assign fill = stb.highFill;
    end
    assign hostDataOut[gi*LANE_W +: LANE_W] =
      !stb.laneOe[gi] ? '0 : (fill ? FILL : src);
  end

  AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.laneOe == 2'b00) |-> (hostDataOut == '0)); // R11
  AST_HIGH_LANE_ODD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.laneOe[1] && !stb.highFill) |-> (hostDataOut[BUS_W-1:LANE_W] == oddRdData)); // R7
  AST_WRDATA_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.oddWr && stb.oddFromHigh) |-> (oddWrData == $past(hostDataIn[BUS_W-1:LANE_W]))); // R10
endmodule

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer
  import pccard_lane_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ce1N,
  input  logic                ce2N,
  input  logic                addr0,
  input  logic                oeN,
  input  logic                weN,
  input  logic                regN,
  input  logic [2*LANE_W-1:0] hostDataIn,
  output logic [2*LANE_W-1:0] hostDataOut,
  output logic [1:0]          hostLaneOe,
  output logic                lowLaneFromOdd,
  input  logic [LANE_W-1:0]   evenRdData,
  input  logic [LANE_W-1:0]   oddRdData,
  output logic                evenRdEn,
  output logic                oddRdEn,
  output logic                evenWrStb,
  output logic                oddWrStb,
  output logic [LANE_W-1:0]   evenWrData,
  output logic [LANE_W-1:0]   oddWrData,
  output logic                attrSpace
);
  laneStrobes_t stb;

  pccard_lane_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2N(ce2N), .addr0(addr0),
    .oeN(oeN), .weN(weN), .regN(regN), .stb(stb)
  );

  pccard_lane_dp #(.LANE_W(LANE_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostDataIn(hostDataIn),
    .evenRdData(evenRdData), .oddRdData(oddRdData),
    .hostDataOut(hostDataOut), .evenWrData(evenWrData), .oddWrData(oddWrData)
  );

  assign hostLaneOe     = stb.laneOe;
  assign lowLaneFromOdd = stb.lowFromOdd;
  assign evenRdEn       = stb.evenRd;
  assign oddRdEn        = stb.oddRd;
  assign evenWrStb      = stb.evenWr;
  assign oddWrStb       = stb.oddWr;
  assign attrSpace      = stb.attr;
endmodule

// File: tb/pccard_lane_steer_test.sv
`timescale 1ns/1ps
module pccard_lane_steer_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, ce1N, ce2N, addr0, oeN, weN, regN;
  logic [15:0] hostDataIn, hostDataOut;
  logic [7:0] evenRdData, oddRdData, evenWrData, oddWrData;
  logic [1:0] hostLaneOe;
  logic lowLaneFromOdd, evenRdEn, oddRdEn, evenWrStb, oddWrStb, attrSpace;

  pccard_lane_steer uut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  logic [1:0] eOe;
  logic eLowOdd, eEvRd, eOdRd, eEvWr, eOdWr, eAttr;
  logic [15:0] eOut;
  logic [7:0] eEvWd, eOdWd;
  string eTag;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic c1, logic c2, logic a, logic o, logic w, logic r,
                       logic [15:0] hin, logic [7:0] evr, logic [7:0] odr);
    bit rd, wr;
    ce1N = c1; ce2N = c2; addr0 = a; oeN = o; weN = w; regN = r;
    hostDataIn = hin; evenRdData = evr; oddRdData = odr;
    rd = (o == 0) && (w == 1);
    wr = (w == 0) && (o == 1);
    eOe = 0; eLowOdd = 0; eEvRd = 0; eOdRd = 0; eEvWr = 0; eOdWr = 0;
    eOut = 0; eEvWd = 0; eOdWd = 0;
    eAttr = !r && !(c1 && c2);
    if (c1 && c2) eTag = "R2";
    else if (!c1 && c2 && !a) begin
      eTag = "R4";
      if (rd) begin eOe = 2'b01; eEvRd = 1; eOut = {8'h00, evr}; end
      if (wr) begin eEvWr = 1; eEvWd = hin[7:0]; end
    end else if (!c1 && c2) begin
      eTag = "R5";
      if (rd) begin eOe = 2'b01; eLowOdd = 1; eOdRd = r; eOut = {8'h00, r ? odr : 8'hFF}; end
      if (wr && r) begin eOdWr = 1; eOdWd = hin[7:0]; end
    end else if (!c1 && !c2) begin
      eTag = "R6";
      if (rd) begin eOe = 2'b11; eEvRd = 1; eOdRd = r; eOut = {r ? odr : 8'hFF, evr}; end
      if (wr) begin eEvWr = 1; eEvWd = hin[7:0]; eOdWr = r; eOdWd = hin[15:8]; end
    end else begin
      eTag = "R7";
      if (rd) begin eOe = 2'b10; eOdRd = r; eOut = {r ? odr : 8'hFF, 8'h00}; end
      if (wr && r) begin eOdWr = 1; eOdWd = hin[15:8]; end
    end
    if (!r && !(c1 && c2)) eTag = {eTag, " R8"};
    if (!rd && !wr) eTag = {eTag, " R3"};
  endtask

  task automatic checkNow();
    chk({eTag, " R9"}, "laneOe", hostLaneOe, eOe);
    chk(eTag, "lowFromOdd", lowLaneFromOdd, eLowOdd);
    chk(eTag, "evenRdEn", evenRdEn, eEvRd);
    chk(eTag, "oddRdEn", oddRdEn, eOdRd);
    chk({eTag, " R9"}, "evenWrStb", evenWrStb, eEvWr);
    chk({eTag, " R9"}, "oddWrStb", oddWrStb, eOdWr);
    chk(eTag, "attrSpace", attrSpace, eAttr);
    chk({eTag, " R11"}, "dataOut", hostDataOut, eOut);
    if (eEvWr && evenWrStb) chk({eTag, " R10"}, "evenWrData", evenWrData, eEvWd);
    if (eOdWr && oddWrStb)  chk({eTag, " R10"}, "oddWrData", oddWrData, eOdWd);
  endtask

  task automatic checkReset();
    chk("R1", "laneOe", hostLaneOe, 0);
    chk("R1", "strobes", {lowLaneFromOdd, evenRdEn, oddRdEn, evenWrStb, oddWrStb, attrSpace}, 0);
    chk("R1", "dataOut", hostDataOut, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0;
    apply(1, 1, 0, 1, 1, 1, 16'h0, 8'h0, 8'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkReset();
    rstN = 1;
    apply(0, 0, 0, 0, 1, 1, 16'h1234, 8'h5A, 8'hA5);
    for (int pass = 0; pass < 4; pass++) begin
      for (int v = 0; v < 64; v++) begin
        @(negedge clk);
        checkNow();
        apply(v[5], v[4], v[3], v[2], v[1], v[0],
              16'(v * 16'h0413 + pass * 16'h1F07 + 16'h3C91),
              8'(v * 7 + pass * 29 + 3), 8'(v * 11 + pass * 53 + 129));
      end
    end
    @(negedge clk);
    checkNow();
    // reset in mid-traffic after a word read
    apply(0, 0, 1, 0, 1, 1, 16'hBEEF, 8'h11, 8'h22);
    @(negedge clk);
    checkNow();
    rstN = 0;
    #1;
    checkReset();
    @(negedge clk);
    checkReset();
    rstN = 1;
    apply(1, 0, 0, 1, 0, 1, 16'hC3A5, 8'h00, 8'h00);
    @(negedge clk);
    checkNow();
    apply(1, 1, 0, 1, 1, 1, 16'h0, 8'h0, 8'h0);
    @(negedge clk);
    checkNow();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule